// File: doc/BRIEF.md
# Transmit Collision and Deferral Status Tracker

This block follows a single half-duplex transmit attempt from its start strobe to its end and assembles the 9-bit status word that is reported once the attempt finishes. While a packet is in progress it tallies collision strobes and times how long the transmitter has been held off by carrier sense, measured in bit-time ticks. The attempt ends in one of three ways: the transmitter reports success, the collision retry limit is reached, or deferral checking is enabled and the deferral time grows past its limit. On that cycle the status word is captured and a one-cycle valid pulse is raised.

Backoff timing, frame serialization and register access are handled elsewhere. The tracker only observes strobes and produces the status word with its valid pulse. Outside of a packet (after reset, or after an attempt has ended and before the next start strobe) every strobe except the start strobe is ignored.

Top module: `txStatusTracker`

## Requirements
- R1: On the 16th collision strobe of a packet, the attempt ends; the status word captured has the excessive-collisions flag at bit 8 set.
- R2: When the attempt ends by a success strobe, bits 6:3 hold the number of collision strobes seen in earlier cycles of the packet (0 to 15).
- R3: Whenever bit 8 is set in the captured status word, the count field at bits 6:3 reads zero, because the count is not meaningful then.
- R4: With the deferral-check enable high, once more than 24288 deferral bit times have accumulated in the packet, the attempt ends on the next cycle and bit 2 (excessive deferral) is set.
- R5: With the deferral-check enable low, no length of deferral ends the attempt; bit 2 stays clear.
- R6: Bit 0 (deferred) is set when the defer input was high in any cycle of the packet before the ending cycle.
- R7: Bits 7 and 1 of the status word are always zero.
- R8: A start strobe clears the collision count, the deferral timer and all flags; nothing from an earlier packet appears in the next status.
- R9: The deferral timer advances only on cycles where both the bit-time tick and the defer input are high; defer without ticks, or ticks without defer, never cause an abort.
- R10: The valid output pulses high for exactly one cycle, in the cycle after the ending event; the status word changes only together with that pulse and holds its value otherwise.
- R11: Collision, success and defer strobes while no packet is in progress have no effect on the outputs.
- R12: Within one cycle, a start strobe overrides every other event; among the endings, the collision limit wins over excessive deferral, which wins over success.
- R13: A synchronous active-high reset clears the valid output, the status word and all internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pktStart | input | 1 | Start of a new transmit attempt |
| collPulse | input | 1 | One collision occurred this cycle |
| deferIn | input | 1 | Transmitter is deferring to carrier |
| bitTick | input | 1 | One bit time has elapsed |
| deferChkEn | input | 1 | Enables the excessive-deferral abort |
| txOkPulse | input | 1 | Packet was transmitted successfully |
| statusValid | output | 1 | One-cycle pulse when a status word is captured |
| statusWord | output | 9 | Captured status: bit 8 excessive collisions, bits 6:3 collision count, bit 2 excessive deferral, bit 0 deferred, bits 7 and 1 zero |

## Verification
Directed packets with 0, 3, 15 and 16 collisions separate a correct count from an off-by-one limit, and the 16-collision case tells the abort path apart from a count field that merely wraps. Long deferral runs with the check on, with it off, with defer but no ticks, and with ticks but no defer distinguish the timer's gating and the exact abort cycle. Same-cycle collisions of start, success and limit events expose the priority order, and a fixed-seed random mix of strobes inside and between packets, compared each cycle against a bench model, catches leakage between packets and reaction to strobes while idle.

// File: rtl/txStatPkg.sv
package txStatPkg;

  localparam int STATUS_W     = 9;
  localparam int EXC_COLL_BIT = 8;
  localparam int CNT_LSB      = 3;
  localparam int CNT_FIELD_W  = 4;
  localparam int EXC_DEF_BIT  = 2;
  localparam int DEFERRED_BIT = 0;

  // Strobes from control to datapath, one per cycle.
  typedef struct packed {
    logic clearAll;
    logic countColl;
    logic countDefer;
    logic markDeferred;
    logic latchStatus;
    logic excColl;
    logic excDefer;
  } txStatStrobes_t;

endpackage

// File: rtl/txStatCtrl.sv
module txStatCtrl
  import txStatPkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           pktStart,
  input  logic           collPulse,
  input  logic           deferIn,
  input  logic           bitTick,
  input  logic           deferChkEn,
  input  logic           txOkPulse,
  input  logic           collAtLimit,
  input  logic           deferOver,
  output txStatStrobes_t strobes
);

  logic active;
  logic live;
  logic endColl;
  logic endDefer;
  logic endOk;
  logic anyEnd;

  // Events only count inside a packet and not in a start cycle.
  assign live     = active && !pktStart;
  assign endColl  = live && collPulse && collAtLimit;
  assign endDefer = live && deferChkEn && deferOver && !endColl;
  assign endOk    = live && txOkPulse && !endColl && !endDefer;
  assign anyEnd   = endColl || endDefer || endOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
    end else if (pktStart) begin
      active <= 1'b1;
    end else if (anyEnd) begin
      active <= 1'b0;
    end
  end

  always_comb begin
    strobes              = '0;
    strobes.clearAll     = pktStart;
    strobes.countColl    = live && collPulse;
    strobes.countDefer   = live && deferIn && bitTick;
    strobes.markDeferred = live && deferIn;
    strobes.latchStatus  = anyEnd;
    strobes.excColl      = endColl;
    strobes.excDefer     = endDefer;
  end

endmodule

// File: rtl/txStatData.sv
module txStatData
  import txStatPkg::*;
#(
  parameter int COLL_LIMIT  = 16,
  parameter int DEFER_LIMIT = 24288
) (
  input  logic                clk,
  input  logic                rst,
  input  txStatStrobes_t      strobes,
  output logic                collAtLimit,
  output logic                deferOver,
  output logic                statusValid,
  output logic [STATUS_W-1:0] statusWord
);

  localparam int COLL_W = $clog2(COLL_LIMIT);
  localparam int DEF_W  = $clog2(DEFER_LIMIT + 2);

  logic [COLL_W-1:0]   collCount;
  logic [DEF_W-1:0]    deferTimer;
  logic                deferredFlag;
  logic [STATUS_W-1:0] nextStatus;

  assign collAtLimit = (collCount == COLL_W'(COLL_LIMIT - 1));
  assign deferOver   = (deferTimer > DEF_W'(DEFER_LIMIT));

  always_comb begin
    nextStatus = '0;
    nextStatus[EXC_COLL_BIT] = strobes.excColl;
    nextStatus[CNT_LSB +: CNT_FIELD_W] =
      strobes.excColl ? '0 : CNT_FIELD_W'(collCount);
    nextStatus[EXC_DEF_BIT]  = strobes.excDefer;
    nextStatus[DEFERRED_BIT] = deferredFlag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collCount    <= '0;
      deferTimer   <= '0;
      deferredFlag <= 1'b0;
    end else if (strobes.clearAll) begin
      collCount    <= '0;
      deferTimer   <= '0;
      deferredFlag <= 1'b0;
    end else begin
      if (strobes.countColl) begin
        collCount <= collCount + 1'b1;
      end
      // Saturate one step past the limit.
      if (strobes.countDefer && !deferOver) begin
        deferTimer <= deferTimer + 1'b1;
      end
      if (strobes.markDeferred) begin
        deferredFlag <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusValid <= 1'b0;
      statusWord  <= '0;
    end else begin
      statusValid <= strobes.latchStatus;
      if (strobes.latchStatus) begin
        statusWord <= nextStatus;
      end
    end
  end

endmodule

// File: rtl/txStatusTracker.sv
module txStatusTracker
  import txStatPkg::*;
#(
  parameter int COLL_LIMIT  = 16,
  parameter int DEFER_LIMIT = 24288
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pktStart,
  input  logic       collPulse,
  input  logic       deferIn,
  input  logic       bitTick,
  input  logic       deferChkEn,
  input  logic       txOkPulse,
  output logic       statusValid,
  output logic [8:0] statusWord
);

  txStatStrobes_t strobes;
  logic           collAtLimit;
  logic           deferOver;

  txStatCtrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .pktStart   (pktStart),
    .collPulse  (collPulse),
    .deferIn    (deferIn),
    .bitTick    (bitTick),
    .deferChkEn (deferChkEn),
    .txOkPulse  (txOkPulse),
    .collAtLimit(collAtLimit),
    .deferOver  (deferOver),
    .strobes    (strobes)
  );

  txStatData #(
    .COLL_LIMIT (COLL_LIMIT),
    .DEFER_LIMIT(DEFER_LIMIT)
  ) u_data (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .collAtLimit(collAtLimit),
    .deferOver  (deferOver),
    .statusValid(statusValid),
    .statusWord (statusWord)
  );

endmodule

// File: rtl/txStatusTrackerChk.sv
module txStatusTrackerChk (
  input logic       clk,
  input logic       rst,
  input logic       statusValid,
  input logic [8:0] statusWord
);

  // R3: count field blank when excessive collisions is reported
  a_r3_count_blank: assert property (@(posedge clk) disable iff (rst)
    (statusValid && statusWord[8]) |-> (statusWord[6:3] == 4'd0));

  // R7: reserved bits stay zero
  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (statusWord[7] == 1'b0) && (statusWord[1] == 1'b0));

  // R10: valid is a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    statusValid |=> !statusValid);

  // R10: word holds between pulses
  a_r10_word_hold: assert property (@(posedge clk) disable iff (rst)
    !statusValid |-> $stable(statusWord));

  // R12: only one abort cause per status
  a_r12_one_abort: assert property (@(posedge clk) disable iff (rst)
    statusValid |-> !(statusWord[8] && statusWord[2]));

  // R4: excessive deferral implies the packet deferred
  a_r4_defer_flag: assert property (@(posedge clk) disable iff (rst)
    (statusValid && statusWord[2]) |-> statusWord[0]);

  // R13: reset clears outputs
  a_r13_reset_clears: assert property (@(posedge clk)
    rst |=> (!statusValid && (statusWord == 9'd0)));

endmodule

bind txStatusTracker txStatusTrackerChk u_chk (
  .clk        (clk),
  .rst        (rst),
  .statusValid(statusValid),
  .statusWord (statusWord)
);

// File: tb/txStatusTracker_tb.sv
`timescale 1ns/1ps
module txStatusTracker_tb;

  localparam int LIM_COLL  = 16;
  localparam int LIM_DEFER = 24288;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pktStart = 1'b0, collPulse = 1'b0, deferIn = 1'b0;
  logic       bitTick = 1'b0, deferChkEn = 1'b0, txOkPulse = 1'b0;
  logic       statusValid;
  logic [8:0] statusWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  txStatusTracker u_dut (
    .clk(clk), .rst(rst), .pktStart(pktStart), .collPulse(collPulse),
    .deferIn(deferIn), .bitTick(bitTick), .deferChkEn(deferChkEn),
    .txOkPulse(txOkPulse), .statusValid(statusValid), .statusWord(statusWord)
  );

  function automatic logic [8:0] mkWord(bit excColl, int cnt, bit excDef, bit deferred);
    logic [8:0] w;
    w = '0;
    w[8] = excColl;
    w[6:3] = excColl ? 4'd0 : 4'(cnt);
    w[2] = excDef;
    w[0] = deferred;
    return w;
  endfunction

  // Reference model built from the requirements.
  bit         mActive, mValid, mDeferred;
  int         mColl, mDefT;
  logic [8:0] mWord;

  always @(posedge clk) begin
    if (rst) begin
      mActive = 0; mValid = 0; mDeferred = 0; mColl = 0; mDefT = 0; mWord = '0;
    end else begin
      mValid = 0;
      if (pktStart) begin
        mActive = 1; mColl = 0; mDefT = 0; mDeferred = 0;
      end else if (mActive) begin
        if (collPulse && mColl == LIM_COLL - 1) begin
          mWord = mkWord(1, 0, 0, mDeferred); mValid = 1;
        end else if (deferChkEn && mDefT > LIM_DEFER) begin
          mWord = mkWord(0, mColl, 1, mDeferred); mValid = 1;
        end else if (txOkPulse) begin
          mWord = mkWord(0, mColl, 0, mDeferred); mValid = 1;
        end
        if (collPulse) mColl++;
        if (deferIn && bitTick && mDefT <= LIM_DEFER) mDefT++;
        if (deferIn) mDeferred = 1;
        if (mValid) mActive = 0;
      end
    end
  end

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: compare with model at negedge, then drive the next inputs.
  task automatic cyc(bit s, bit c, bit d, bit t, bit ok, bit en);
    @(negedge clk);
    check("R10 valid vs model", 9'(statusValid), 9'(mValid));
    if (statusValid) begin
      check("R1/R2/R4/R6 word vs model", statusWord, mWord);
      check("R7 reserved bits", 9'({statusWord[7], statusWord[1]}), 9'd0);
    end
    pktStart = s; collPulse = c; deferIn = d; bitTick = t; txOkPulse = ok; deferChkEn = en;
  endtask

  task automatic idle(bit en = 0);
    cyc(0, 0, 0, 0, 0, en);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle();
    check("R13 reset valid", 9'(statusValid), 9'd0);
    check("R13 reset word", statusWord, 9'd0);

    // R2: clean success
    cyc(1,0,0,0,0,0); cyc(0,0,0,0,1,0); idle();
    check("R2 zero collisions", {statusValid, statusWord}, {1'b1, mkWord(0,0,0,0)});
    idle();
    check("R10 pulse drops", 9'(statusValid), 9'd0);

    // R2: three collisions
    cyc(1,0,0,0,0,0);
    for (int i = 0; i < 3; i++) cyc(0,1,0,0,0,0);
    cyc(0,0,0,0,1,0); idle();
    check("R2 three collisions", statusWord, mkWord(0,3,0,0));

    // R6: deferral then success
    cyc(1,0,0,0,0,0);
    for (int i = 0; i < 5; i++) cyc(0,0,1,1,0,0);
    cyc(0,0,0,0,1,0); idle();
    check("R6 deferred flag", statusWord, mkWord(0,0,0,1));

    // R2: fifteen collisions, boundary below the limit
    cyc(1,0,0,0,0,0);
    for (int i = 0; i < 15; i++) cyc(0,1,0,0,0,0);
    cyc(0,0,0,0,1,0); idle();
    check("R2 fifteen collisions", statusWord, mkWord(0,15,0,0));

    // R1/R3: sixteenth collision aborts
    cyc(1,0,0,0,0,0);
    for (int i = 0; i < 15; i++) cyc(0,1,0,0,0,0);
    idle();
    check("R1 no abort at fifteen", 9'(statusValid), 9'd0);
    cyc(0,1,0,0,0,0); idle();
    check("R1 abort at sixteen", {statusValid, statusWord}, {1'b1, 9'h100});
    check("R3 count field blank", 9'(statusWord[6:3]), 9'd0);

    // R4: long deferral with check enabled
    cyc(1,0,0,0,0,1);
    for (int i = 0; i < LIM_DEFER + 1; i++) cyc(0,0,1,1,0,1);
    idle(1);
    check("R4 not before limit passed", 9'(statusValid), 9'd0);
    idle(1);
    check("R4 excessive deferral", {statusValid, statusWord}, {1'b1, mkWord(0,0,1,1)});

    // R5: same deferral with check disabled
    cyc(1,0,0,0,0,0);
    for (int i = 0; i < LIM_DEFER + 100; i++) cyc(0,0,1,1,0,0);
    idle();
    check("R5 no abort when disabled", 9'(statusValid), 9'd0);
    cyc(0,0,0,0,1,0); idle();
    check("R5 success after long defer", statusWord, mkWord(0,0,0,1));

    // R9: defer without ticks, then ticks without defer
    cyc(1,0,0,0,0,1);
    for (int i = 0; i < LIM_DEFER + 100; i++) cyc(0,0,1,0,0,1);
    for (int i = 0; i < LIM_DEFER + 100; i++) cyc(0,0,0,1,0,1);
    idle(1);
    check("R9 no abort without gated ticks", 9'(statusValid), 9'd0);
    cyc(0,0,0,0,1,1); idle();
    check("R9 success status", statusWord, mkWord(0,0,0,1));

    // R11: strobes while idle
    cyc(0,1,1,1,1,1); cyc(0,1,0,0,1,0); idle(); idle();
    check("R11 idle valid", 9'(statusValid), 9'd0);
    check("R11 idle word held", statusWord, mkWord(0,0,0,1));

    // R12: collision limit beats success in the same cycle
    cyc(1,0,0,0,0,0);
    for (int i = 0; i < 15; i++) cyc(0,1,0,0,0,0);
    cyc(0,1,0,0,1,0); idle();
    check("R12 limit over success", statusWord, 9'h100);

    // R12: start beats success in the same cycle
    cyc(1,0,0,0,0,0); cyc(1,0,0,0,1,0); idle();
    check("R12 start overrides success", 9'(statusValid), 9'd0);
    cyc(0,0,0,0,1,0); idle();
    check("R12 later success", statusWord, mkWord(0,0,0,0));

    // R8: restart clears earlier packet state
    cyc(1,0,0,0,0,0);
    for (int i = 0; i < 4; i++) cyc(0,1,1,1,0,0);
    cyc(1,0,0,0,0,0); cyc(0,0,0,0,1,0); idle();
    check("R8 restart clears", statusWord, mkWord(0,0,0,0));

    // Random mix against the model
    for (int p = 0; p < 60; p++) begin
      cyc(1, 0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      for (int k = 0; k < 80; k++) begin
        cyc(0, ($urandom % 5) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0,
            ($urandom % 40) == 0, ($urandom % 2) == 0);
        if (!mActive) break;
      end
      for (int k = 0; k < 4; k++)
        cyc(0, ($urandom % 3) == 0, ($urandom % 3) == 0, 1'($urandom % 2),
            ($urandom % 3) == 0, 1'($urandom % 2));
    end
    idle(); idle();

    done = 1'b1;
    finishRun();
  end

endmodule